// File: doc/BRIEF.md
# Masked Multi-Port GPIO Register Block

This block sits on a simple single-cycle local bus and controls five general-purpose I/O ports, each 32 bits wide. Every port has five registers: direction, mask, pin value, set and clear. For each port the block drives an output-data vector and an output-enable vector toward the pads. It also takes a raw pin-input vector, which passes through a two-flop synchroniser before it can be read.

Each port's mask register gates that port's data path. A mask bit of 1 removes the bit from pin-value writes, set writes and clear writes, and a masked bit reads as zero from the pin-value register. Software can therefore change a group of pins in one access without a read-modify-write. Accesses can be a byte, a half-word or a word. The byte-lane strobes choose which lanes a write touches. Reads always return the whole 32-bit register.

Top module: `gpio_mport`

## Requirements
- R1: After reset every register of every port is zero: all output-enable bits are 0, all output bits are 0, and every register reads back as 0 while the pins are low.
- R2: Each port occupies a 0x20-byte window, with port p starting at byte address p*0x20 for p from 0 to 4. Inside the window the offsets are: direction 0x00, mask 0x10, pin value 0x14, set 0x18, clear 0x1C. A write to any other offset, or to an address at or above 0xA0, changes nothing, and a read of such an address returns 0.
- R3: A direction bit of 1 makes its pin an output, so the matching output-enable bit is 1. A direction bit of 0 makes the pin an input. The direction register reads back as written.
- R4: A read of the pin-value register returns the synchronised pin level ANDed with the inverted mask, whatever the pin's direction. A pin change applied before clock edge k is visible to a read only after edge k+1.
- R5: A write to the pin-value register loads the output latch with the write data in every unmasked, strobed bit. Masked bits keep their value.
- R6: A write to the set register drives high each output bit that is unmasked, strobed and written with 1. Bits written with 0 do not change.
- R7: A write to the clear register drives low each output bit that is unmasked, strobed and written with 1. Bits written with 0 do not change. A read of the clear register always returns 0.
- R8: A read of the set register returns the full output latch, without masking.
- R9: A write changes only the bytes whose strobe bit is 1; bus_be[i] covers data bits 8i+7 down to 8i. A write with no strobes changes nothing.
- R10: The output and output-enable vectors change only on the clock edge that completes a bus write, and they change on that edge. A read never changes them.
- R11: The mask register reads back as written. Writes to the mask register are never masked themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte-lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| pin_in | input | 160 | Raw pin levels; port p uses bits 32p+31 down to 32p |
| pin_out | output | 160 | Output latch of each port |
| pin_oe | output | 160 | Output enable of each port (the direction register) |

## Verification
Set and clear are driven with all-ones, all-zeros and alternating-nibble data under masks that cover the low byte, the high half or nothing. This shows whether writing 0 has no effect and whether masked bits are truly protected. Pin-value writes under a half mask tell a direct load apart from a merge with set or clear. Distinct direction patterns on each port tell correct window decoding apart from aliasing, and writes to unused offsets and to the sixth window confirm they are ignored. Single-byte, half-word and zero-strobe writes separate the lane gating from the mask gating. A pin change read one and then two clocks later confirms the synchroniser depth.

// File: rtl/gpio_mport_pkg.sv
// Shared constants and types for the masked multi-port GPIO block.
// Assumes a byte-addressed bus and 32-byte register windows per port.
package gpio_mport_pkg;

    // Each port owns 2**WIN_BITS bytes of address space.
    localparam int WIN_BITS = 5;

    // Register offsets within a window, as word indices (byte offset / 4).
    localparam logic [2:0] WIDX_DIR  = 3'd0;
    localparam logic [2:0] WIDX_MASK = 3'd4;
    localparam logic [2:0] WIDX_PIN  = 3'd5;
    localparam logic [2:0] WIDX_SET  = 3'd6;
    localparam logic [2:0] WIDX_CLR  = 3'd7;

    // Decoded register kind of an access.
    typedef enum logic [2:0] {
        K_NONE,
        K_DIR,
        K_MASK,
        K_PIN,
        K_SET,
        K_CLR
    } reg_kind_e;

endpackage

// File: rtl/gpio_addr_dec.sv
// Address decoder: splits a word address into a one-hot port hit vector and
// a register kind. Assumes the byte-within-word bits are already dropped.
module gpio_addr_dec
    import gpio_mport_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-3:0]    word_addr,
    output logic [NUM_PORTS-1:0] port_hit,
    output reg_kind_e            kind
);

    localparam int PIDX_W = ADDR_W - WIN_BITS;
    localparam int OFF_W  = WIN_BITS - 2;

    logic [PIDX_W-1:0] port_idx;
    logic [OFF_W-1:0]  word_off;

    assign port_idx = word_addr[ADDR_W-3:OFF_W];
    assign word_off = word_addr[OFF_W-1:0];

    // One comparator per port window.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign port_hit[p] = (port_idx == PIDX_W'(p));
    end

    // Map the word offset inside a window onto a register kind.
    always_comb begin
        unique case (word_off)
            WIDX_DIR:  kind = K_DIR;
            WIDX_MASK: kind = K_MASK;
            WIDX_PIN:  kind = K_PIN;
            WIDX_SET:  kind = K_SET;
            WIDX_CLR:  kind = K_CLR;
            default:   kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_lane_mask.sv
// Expands byte-lane strobes into a per-bit enable vector.
// Assumes the data width is a whole number of bytes.
module gpio_lane_mask #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   bit_en
);

    localparam int LANES = DATA_W / 8;

    // Replicate each strobe across its byte.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bit_en[l*8 +: 8] = {8{be[l]}};
    end

endmodule

// File: rtl/gpio_sync2.sv
// Two-flop synchroniser for asynchronous pin levels; resets to zero.
// Assumes each bit is independent (no multi-bit coherence needed).
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/gpio_port.sv
// One GPIO port: direction, mask and output latch registers, the input
// synchroniser and the register read path. Assumes wr_en is already
// qualified by the bus select and this port's address hit.
module gpio_port
    import gpio_mport_pkg::*;
#(
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] lane_en,
    input  logic [PORT_W-1:0] pin_raw,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] rd_data
);

    logic [PORT_W-1:0] mask_q;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] data_en;

    // Bits a data write may touch: strobed and not masked.
    assign data_en = lane_en & ~mask_q;

    // Synchronise the raw pin levels.
    gpio_sync2 #(.W(PORT_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_raw),
        .sync_out (pin_sync)
    );

    // Direction register, byte-lane gated only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_en && kind == K_DIR) begin
            dir_q <= (dir_q & ~lane_en) | (wdata & lane_en);
        end
    end

    // Mask register, byte-lane gated only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && kind == K_MASK) begin
            mask_q <= (mask_q & ~lane_en) | (wdata & lane_en);
        end
    end

    // Output latch: load, set or clear under lane and mask gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en) begin
            unique case (kind)
                K_PIN:   out_q <= (out_q & ~data_en) | (wdata & data_en);
                K_SET:   out_q <= out_q | (wdata & data_en);
                K_CLR:   out_q <= out_q & ~(wdata & data_en);
                default: out_q <= out_q;
            endcase
        end
    end

    // Register read selection for this port.
    always_comb begin
        unique case (kind)
            K_DIR:   rd_data = dir_q;
            K_MASK:  rd_data = mask_q;
            K_PIN:   rd_data = pin_sync & ~mask_q;
            K_SET:   rd_data = out_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mport.sv
// Top of the masked multi-port GPIO block. A single-cycle local-bus slave
// writes on the clock edge and returns read data combinationally in the
// same cycle. Assumes bus_addr is word aligned for register selection; the
// two low address bits are not used, and bus_be selects the lanes.
module gpio_mport
    import gpio_mport_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [PORT_W/8-1:0]         bus_be,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe
);

    logic [NUM_PORTS-1:0] port_hit;
    reg_kind_e            kind;
    logic [PORT_W-1:0]    lane_en;
    logic [PORT_W-1:0]    port_rd [NUM_PORTS];
    logic                 unused_low;

    assign unused_low = ^bus_addr[1:0];

    // Decode the window and register kind.
    gpio_addr_dec #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .word_addr (bus_addr[ADDR_W-1:2]),
        .port_hit  (port_hit),
        .kind      (kind)
    );

    // Expand the strobes into a bit enable.
    gpio_lane_mask #(.DATA_W(PORT_W)) u_lanes (
        .be     (bus_be),
        .bit_en (lane_en)
    );

    // One register set per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_port #(.PORT_W(PORT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_sel && bus_wr && port_hit[p]),
            .kind    (kind),
            .wdata   (bus_wdata),
            .lane_en (lane_en),
            .pin_raw (pin_in[p*PORT_W +: PORT_W]),
            .out_q   (pin_out[p*PORT_W +: PORT_W]),
            .dir_q   (pin_oe[p*PORT_W +: PORT_W]),
            .rd_data (port_rd[p])
        );
    end

    // Return the selected port's read data during a read, else zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (port_hit[p]) begin
                    bus_rdata = bus_rdata | port_rd[p];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_mport_chk.sv
// Property checker for gpio_mport, attached by bind. Observes the bus and
// the pad-side outputs only.
module gpio_mport_chk #(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [PORT_W/8-1:0]         bus_be,
    input logic [PORT_W-1:0]           bus_rdata,
    input logic [NUM_PORTS*PORT_W-1:0] pin_out,
    input logic [NUM_PORTS*PORT_W-1:0] pin_oe
);

    logic [2:0] woff;
    logic       wr_now, rd_now, unused_hi;

    assign woff      = bus_addr[4:2];
    assign wr_now    = bus_sel && bus_wr;
    assign rd_now    = bus_sel && !bus_wr;
    assign unused_hi = ^bus_addr[ADDR_W-1:5] ^ ^bus_addr[1:0];

    // Outputs only move on the edge after a write.
    assert_quiet_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_now) |-> ($stable(pin_out) && $stable(pin_oe)));

    // A set write never lowers any output bit.
    assert_set_never_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_now && woff == 3'd6) |-> ((~pin_out & $past(pin_out)) == '0));

    // A clear write never raises any output bit.
    assert_clr_never_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_now && woff == 3'd7) |-> ((pin_out & ~$past(pin_out)) == '0));

    // The clear register reads as zero.
    assert_clr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && woff == 3'd7) |-> (bus_rdata == '0));

    // A write with no strobes leaves everything alone.
    assert_no_lane_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_now && bus_be == '0) |-> ($stable(pin_out) && $stable(pin_oe)));

    // Unused offsets inside a window are ignored on write.
    assert_unused_offset_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_now && woff >= 3'd1 && woff <= 3'd3) |-> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_mport gpio_mport_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mport_bench.sv
`timescale 1ns/1ps
// Directed bench for gpio_mport: one task per scenario, with a reference
// model of the registers kept in the bench.
module gpio_mport_bench;

    localparam int NP = 5;
    localparam int W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [W-1:0]      bus_wdata = '0;
    logic [W-1:0]      bus_rdata;
    logic [NP*W-1:0]   pin_in = '0;
    logic [NP*W-1:0]   pin_out;
    logic [NP*W-1:0]   pin_oe;

    logic [W-1:0] m_dir  [NP];
    logic [W-1:0] m_mask [NP];
    logic [W-1:0] m_out  [NP];

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    gpio_mport u_gpio_mport (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Write one register; the model follows the requirements.
    task automatic bus_write(input int p, input logic [4:0] off, input logic [3:0] be,
                             input logic [W-1:0] d);
        logic [W-1:0] lanes, en;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
        bus_addr = 8'(p * 32) + 8'(off);
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
        if (p < NP) begin
            for (int l = 0; l < 4; l++) lanes[l*8 +: 8] = {8{be[l]}};
            en = lanes & ~m_mask[p];
            case (off)
                5'h00: m_dir[p]  = (m_dir[p] & ~lanes) | (d & lanes);
                5'h10: m_mask[p] = (m_mask[p] & ~lanes) | (d & lanes);
                5'h14: m_out[p]  = (m_out[p] & ~en) | (d & en);
                5'h18: m_out[p]  = m_out[p] | (d & en);
                5'h1C: m_out[p]  = m_out[p] & ~(d & en);
                default: ;
            endcase
        end
    endtask

    task automatic bus_read(input int p, input logic [4:0] off, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(p * 32) + 8'(off);
        #1;
        d = bus_rdata;
        #1;
        bus_sel = 1'b0;
    endtask

    // Compare every port's pad outputs with the model, away from the edge.
    task automatic check_pads(input string req);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            check({req, " out"}, pin_out[p*W +: W], m_out[p]);
            check({req, " oe"},  pin_oe[p*W +: W],  m_dir[p]);
        end
    endtask

    task automatic t_reset_R1();
        logic [W-1:0] d;
        check_pads("R1");
        for (int p = 0; p < NP; p++) begin
            bus_read(p, 5'h00, d); check("R1 dir", d, '0);
            bus_read(p, 5'h10, d); check("R1 mask", d, '0);
            bus_read(p, 5'h14, d); check("R1 pin", d, '0);
            bus_read(p, 5'h18, d); check("R1 set", d, '0);
        end
    endtask

    task automatic t_map_R2_R3();
        logic [W-1:0] d;
        for (int p = 0; p < NP; p++) bus_write(p, 5'h00, 4'hF, 32'h0101_0101 * (p + 1));
        check_pads("R3 window");
        for (int p = 0; p < NP; p++) begin
            bus_read(p, 5'h00, d); check("R3 dir readback", d, 32'h0101_0101 * (p + 1));
        end
        bus_write(1, 5'h04, 4'hF, 32'hFFFF_FFFF);
        bus_write(2, 5'h0C, 4'hF, 32'hFFFF_FFFF);
        bus_write(5, 5'h00, 4'hF, 32'hFFFF_FFFF);
        bus_write(5, 5'h18, 4'hF, 32'hFFFF_FFFF);
        check_pads("R2 ignored");
        bus_read(1, 5'h04, d); check("R2 unused read", d, '0);
        bus_read(5, 5'h00, d); check("R2 beyond ports", d, '0);
    endtask

    task automatic t_pin_write_R5_R8_R11();
        logic [W-1:0] d;
        bus_write(1, 5'h14, 4'hF, 32'hA5A5_5A5A);
        check_pads("R5 full");
        bus_read(1, 5'h18, d); check("R8 latch", d, 32'hA5A5_5A5A);
        bus_write(1, 5'h10, 4'hF, 32'hFFFF_0000);
        bus_read(1, 5'h10, d); check("R11 mask readback", d, 32'hFFFF_0000);
        bus_write(1, 5'h14, 4'hF, 32'h1234_5678);
        check_pads("R5 masked");
        bus_read(1, 5'h18, d); check("R8 unmasked read", d, 32'hA5A5_5678);
    endtask

    task automatic t_set_clr_R6_R7();
        logic [W-1:0] d;
        bus_write(2, 5'h10, 4'hF, 32'h0000_00FF);
        bus_write(2, 5'h18, 4'hF, 32'hFFFF_FFFF);
        check_pads("R6 set masked");
        bus_write(2, 5'h18, 4'hF, 32'h0000_0000);
        check_pads("R6 zero no effect");
        bus_write(2, 5'h1C, 4'hF, 32'h0F0F_0F0F);
        check_pads("R7 clear");
        bus_write(2, 5'h1C, 4'hF, 32'h0000_0000);
        check_pads("R7 zero no effect");
        bus_read(2, 5'h18, d); check("R7 latch after clear", d, 32'hF0F0_F000);
        bus_read(2, 5'h1C, d); check("R7 clear reads zero", d, '0);
    endtask

    task automatic t_lanes_R9();
        bus_write(3, 5'h18, 4'b0100, 32'hFFFF_FFFF);
        check_pads("R9 byte set");
        bus_write(3, 5'h00, 4'b0011, 32'hFFFF_FFFF);
        check_pads("R9 half dir");
        bus_write(3, 5'h14, 4'b0000, 32'hFFFF_FFFF);
        bus_write(3, 5'h1C, 4'b0000, 32'hFFFF_FFFF);
        check_pads("R9 no strobe");
        bus_write(3, 5'h1C, 4'b1000, 32'hFFFF_FFFF);
        check_pads("R9 byte clear");
    endtask

    task automatic t_pin_read_R4();
        logic [W-1:0] d;
        bus_write(4, 5'h00, 4'hF, 32'h0000_FFFF);
        bus_write(4, 5'h10, 4'hF, 32'hFF00_00FF);
        @(negedge clk);
        pin_in[4*W +: W] = 32'hDEAD_BEEF;
        bus_read(4, 5'h14, d); check("R4 one clock old", d, 32'h0000_0000);
        bus_read(4, 5'h14, d); check("R4 after sync", d, 32'h00AD_BE00);
        @(negedge clk);
        pin_in[4*W +: W] = 32'h1234_5678;
        repeat (2) @(posedge clk);
        bus_read(4, 5'h14, d); check("R4 any direction", d, 32'h0034_5600);
    endtask

    task automatic t_timing_R10();
        logic [W-1:0] d;
        bus_write(0, 5'h14, 4'hF, 32'h8000_0001);
        check_pads("R10 same edge");
        bus_read(0, 5'h18, d);
        bus_read(0, 5'h14, d);
        check_pads("R10 read no change");
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_dir[p] = '0; m_mask[p] = '0; m_out[p] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R1();
        t_map_R2_R3();
        t_pin_write_R5_R8_R11();
        t_set_clr_R6_R7();
        t_lanes_R9();
        t_pin_read_R4();
        t_timing_R10();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule